// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Handshake Stage

This block is a clocked model of one asynchronous half-buffer pipeline stage that moves a single bit. Each side of the stage is a three-wire channel: two data rails and one enable wire. The enable wire is driven by the receiving side. A token is a single raised rail. Rail-0 high means logic 0, rail-1 high means logic 1, and both rails low means the channel is empty. Every transfer is a four-phase, return-to-zero exchange. The sender raises a rail. The receiver latches it and drops its enable. The sender then clears both rails. Finally the receiver raises its enable again once it can take the next token.

Stages connect head to tail to form a linear pipeline: each stage's left enable drives the right enable of the stage before it. Each stage holds at most one token on its output, and an occupied output blocks the stage before it. As a result, a stalled chain fills only every other stage. A configuration option lets the stage come out of reset already holding one token of a chosen value, which is how a ring or pipeline gets seeded. Both rails high at once is an illegal input: the stage reports it and ignores it.

Top module: `dr_stage`

## Requirements
- R1: Rail encoding on both channels, with bit 1 as the one-rail and bit 0 as the zero-rail: 2'b01 carries logic 0, 2'b10 carries logic 1, and 2'b00 is empty. The output token always carries the same value as the input token it was taken from.
- R2: With no initial token configured, in the first cycle after synchronous reset the right rails are 2'b00 and the left enable is 1.
- R3: With an initial token configured, after reset the right rails hold the encoded initial value and the left enable is 0. The token then drains through a normal return-to-zero phase.
- R4: When the output is empty, the input holds a valid token and the right enable is 1 at a clock edge, the output carries that token's encoding from the next cycle.
- R5: While the right enable is 0, an empty output stays empty whatever the input holds.
- R6: A full output returns to 2'b00 on the cycle after an edge where the input is 2'b00 and the right enable is 0. In every other case it holds its value.
- R7: The left enable is 0 exactly while the right rails hold a token, and 1 while they are empty.
- R8: A left input of 2'b11 raises the error output in the same cycle and changes neither the output rails nor the left enable.
- R9: The right rails never show 2'b11.
- R10: In a chain of stages, tokens leave in the order they entered under any stall pattern at the far end. With the far end stalled, a four-stage chain settles holding exactly two tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| lt_rails_i | input | 2 | Incoming dual-rail token, bit 1 one-rail, bit 0 zero-rail |
| lt_en_o | output | 1 | Enable back to the sender, 1 when ready for a new token |
| rt_rails_o | output | 2 | Outgoing dual-rail token |
| rt_en_i | input | 1 | Enable from the receiver |
| rail_err_o | output | 1 | High while the incoming rails are both high |

## Verification
A directed table walks a single stage through input and enable combinations. These separate capture from hold: a valid token offered while the receiver is busy, an input that is still valid when the receiver has already taken the token, and an empty input while the receiver is ready. Logic 0 and logic 1 tokens are both sent, so that the two rails cannot be swapped without notice. The clash pattern is applied once on an empty stage and once on a full stage, to show that it neither launches nor clears a token. A four-stage chain then carries a varied bit sequence under random sink delays and one long stall. Bit order at the sink shows whether a token was dropped or duplicated. The occupancy count during the stall shows half-buffer slack as opposed to full-buffer slack.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef struct packed {
        logic one;
        logic zero;
    } rail_t;

    typedef enum logic [1:0] {
        RC_EMPTY = 2'b00,
        RC_ZERO  = 2'b01,
        RC_ONE   = 2'b10,
        RC_CLASH = 2'b11
    } rail_code_e;

    localparam rail_t RAIL_EMPTY = '{one: 1'b0, zero: 1'b0};

    function automatic rail_t rail_encode(input logic b);
        rail_t r;
        r.one  = b;
        r.zero = ~b;
        return r;
    endfunction

    function automatic rail_code_e rail_classify(input rail_t r);
        return rail_code_e'({r.one, r.zero});
    endfunction

endpackage

// File: rtl/dr_rail_decode.sv
module dr_rail_decode
    import dr_pkg::*;
(
    input  rail_t rails_i,
    output logic  valid_o,
    output logic  empty_o,
    output logic  clash_o,
    output logic  bit_o
);
    rail_code_e code;

    always_comb begin
        code    = rail_classify(rails_i);
        valid_o = (code == RC_ZERO) || (code == RC_ONE);
        empty_o = (code == RC_EMPTY);
        clash_o = (code == RC_CLASH);
        bit_o   = (code == RC_ONE);
    end
endmodule

// File: rtl/dr_stage_ctrl.sv
module dr_stage_ctrl (
    input  logic in_valid_i,
    input  logic in_empty_i,
    input  logic out_full_i,
    input  logic rt_en_i,
    output logic fire_o,
    output logic clear_o
);
    always_comb begin
        fire_o  = ~out_full_i & in_valid_i & rt_en_i;
        clear_o =  out_full_i & in_empty_i & ~rt_en_i;
    end
endmodule

// File: rtl/dr_rail_reg.sv
module dr_rail_reg
    import dr_pkg::*;
#(
    parameter bit INIT_TOKEN = 1'b0,
    parameter bit INIT_VALUE = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  fire_i,
    input  logic  clear_i,
    input  logic  bit_i,
    output rail_t rails_o
);
    localparam rail_t RESET_RAILS = INIT_TOKEN ? rail_encode(INIT_VALUE) : RAIL_EMPTY;

    always_ff @(posedge clk) begin
        if (rst) begin
            rails_o <= RESET_RAILS;
        end else if (fire_i) begin
            rails_o <= rail_encode(bit_i);
        end else if (clear_i) begin
            rails_o <= RAIL_EMPTY;
        end
    end
endmodule

// File: rtl/dr_stage.sv
module dr_stage
    import dr_pkg::*;
#(
    parameter bit INIT_TOKEN = 1'b0,
    parameter bit INIT_VALUE = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] lt_rails_i,
    output logic       lt_en_o,
    output logic [1:0] rt_rails_o,
    input  logic       rt_en_i,
    output logic       rail_err_o
);
    rail_t in_rails;
    rail_t out_rails;
    logic  in_valid, in_empty, in_clash, in_bit;
    logic  out_full, fire, clear;

    assign in_rails = rail_t'(lt_rails_i);

    dr_rail_decode u_dec (
        .rails_i (in_rails),
        .valid_o (in_valid),
        .empty_o (in_empty),
        .clash_o (in_clash),
        .bit_o   (in_bit)
    );

    dr_stage_ctrl u_ctrl (
        .in_valid_i (in_valid),
        .in_empty_i (in_empty),
        .out_full_i (out_full),
        .rt_en_i    (rt_en_i),
        .fire_o     (fire),
        .clear_o    (clear)
    );

    dr_rail_reg #(
        .INIT_TOKEN (INIT_TOKEN),
        .INIT_VALUE (INIT_VALUE)
    ) u_reg (
        .clk     (clk),
        .rst     (rst),
        .fire_i  (fire),
        .clear_i (clear),
        .bit_i   (in_bit),
        .rails_o (out_rails)
    );

    assign out_full   = (rail_classify(out_rails) != RC_EMPTY);
    assign lt_en_o    = ~out_full;
    assign rt_rails_o = out_rails;
    assign rail_err_o = in_clash;
endmodule

// File: rtl/dr_stage_chk.sv
module dr_stage_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] lt_rails_i,
    input logic       lt_en_o,
    input logic [1:0] rt_rails_o,
    input logic       rt_en_i,
    input logic       rail_err_o
);
    logic in_tok;
    assign in_tok = (lt_rails_i == 2'b01) || (lt_rails_i == 2'b10);

    // R9
    out_never_clash_chk: assert property (@(posedge clk) disable iff (rst)
        rt_rails_o != 2'b11);

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (rt_rails_o == 2'b00 && in_tok && rt_en_i) |=> (rt_rails_o == $past(lt_rails_i)));

    // R5
    busy_hold_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (rt_rails_o == 2'b00 && !rt_en_i) |=> (rt_rails_o == 2'b00));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (rt_rails_o != 2'b00 && lt_rails_i == 2'b00 && !rt_en_i) |=> (rt_rails_o == 2'b00));

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rt_rails_o != 2'b00 && !(lt_rails_i == 2'b00 && !rt_en_i)) |=> $stable(rt_rails_o));

    // R7
    enable_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        lt_en_o == (rt_rails_o == 2'b00));

    // R8
    clash_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (lt_rails_i == 2'b11) |-> rail_err_o);

    // R8
    clash_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (lt_rails_i == 2'b11) |=> $stable(rt_rails_o));
endmodule

bind dr_stage dr_stage_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .lt_rails_i (lt_rails_i),
    .lt_en_o    (lt_en_o),
    .rt_rails_o (rt_rails_o),
    .rt_en_i    (rt_en_i),
    .rail_err_o (rail_err_o)
);

// File: tb/dr_stage_tb_top.sv
module dr_stage_tb_top;
    localparam int NTOK = 40;
    localparam int NVEC = 12;
    // {in_rails[1:0], rt_en, exp_out[1:0], exp_lt_en, exp_err}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b00_1_00_1_0,
        7'b01_0_00_1_0,
        7'b01_1_01_0_0,
        7'b00_1_01_0_0,
        7'b01_0_01_0_0,
        7'b00_0_00_1_0,
        7'b10_0_00_1_0,
        7'b11_1_00_1_1,
        7'b10_1_10_0_0,
        7'b11_0_10_0_1,
        7'b10_0_10_0_0,
        7'b00_0_00_1_0
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [1:0] a_in = 2'b00;
    logic       a_ren = 1'b1;
    logic [1:0] a_out;
    logic       a_len, a_err;

    logic [1:0] b_in = 2'b00;
    logic       b_ren = 1'b1;
    logic [1:0] b_out;
    logic       b_len, b_err;

    logic [1:0] src = 2'b00;
    logic       sink_en = 1'b1;
    logic [1:0] d0, d1, d2, d3;
    logic       e0, e1, e2, e3;
    logic [3:0] ce;

    dr_stage dut_i (.clk(clk), .rst(rst), .lt_rails_i(a_in), .lt_en_o(a_len),
        .rt_rails_o(a_out), .rt_en_i(a_ren), .rail_err_o(a_err));

    dr_stage #(.INIT_TOKEN(1'b1), .INIT_VALUE(1'b1)) init_i (.clk(clk), .rst(rst),
        .lt_rails_i(b_in), .lt_en_o(b_len), .rt_rails_o(b_out), .rt_en_i(b_ren),
        .rail_err_o(b_err));

    dr_stage c0 (.clk(clk), .rst(rst), .lt_rails_i(src), .lt_en_o(e0),
        .rt_rails_o(d0), .rt_en_i(e1), .rail_err_o(ce[0]));
    dr_stage c1 (.clk(clk), .rst(rst), .lt_rails_i(d0), .lt_en_o(e1),
        .rt_rails_o(d1), .rt_en_i(e2), .rail_err_o(ce[1]));
    dr_stage c2 (.clk(clk), .rst(rst), .lt_rails_i(d1), .lt_en_o(e2),
        .rt_rails_o(d2), .rt_en_i(e3), .rail_err_o(ce[2]));
    dr_stage c3 (.clk(clk), .rst(rst), .lt_rails_i(d2), .lt_en_o(e3),
        .rt_rails_o(d3), .rt_en_i(sink_en), .rail_err_o(ce[3]));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic seq_bit(input int k);
        logic [7:0] h;
        h = 8'(k * 37 + 11);
        return h[2] ^ h[5];
    endfunction

    task automatic run_source();
        int sidx = 0;
        while (sidx < NTOK || src != 2'b00) begin
            @(negedge clk);
            if (src == 2'b00 && e0 && sidx < NTOK) begin
                src = seq_bit(sidx) ? 2'b10 : 2'b01;
                sidx++;
            end else if (src != 2'b00 && !e0) begin
                src = 2'b00;
            end
        end
    endtask

    task automatic run_sink();
        int ridx = 0;
        while (ridx < NTOK) begin
            @(negedge clk);
            if (sink_en && d3 != 2'b00) begin
                // R10 order and R1 value through the chain
                check("R10", int'(d3), seq_bit(ridx) ? 2 : 1);
                ridx++;
                sink_en = 1'b0;
                if (ridx == 20) begin
                    repeat (40) @(negedge clk);
                    // R10 half-buffer occupancy
                    check("R10", int'(d0 != 0) + int'(d1 != 0) + int'(d2 != 0) + int'(d3 != 0), 2);
                end
            end else if (!sink_en && d3 == 2'b00) begin
                repeat ($urandom_range(0, 3)) @(negedge clk);
                sink_en = 1'b1;
            end else if (sink_en) begin
                repeat ($urandom_range(0, 2)) @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2
        check("R2", int'(a_out), 0);
        check("R2", int'(a_len), 1);
        // R3
        check("R3", int'(b_out), 2);
        check("R3", int'(b_len), 0);
        b_ren = 1'b0;
        @(posedge clk); #1;
        check("R3", int'(b_out), 0);
        check("R7", int'(b_len), 1);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            a_in  = VEC[i][6:5];
            a_ren = VEC[i][4];
            @(posedge clk); #1;
            // R1 R4 R5 R6 output rails
            check("R4/R5/R6", int'(a_out), int'(VEC[i][3:2]));
            // R7
            check("R7", int'(a_len), int'(VEC[i][1]));
            // R8
            check("R8", int'(a_err), int'(VEC[i][0]));
            // R9
            check("R9", int'(a_out == 2'b11), 0);
        end

        fork
            run_source();
            run_sink();
        join
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10: watchdog expired, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule